// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial-bus front end and a non-volatile memory array. A write transaction opens with a start pulse that carries a base address. The upper address bits name a row, or page, and the low six bits name a starting column. Data bytes then arrive one at a time and land in a 64-entry page buffer. Each slot carries a written flag. After each byte the column advances within the row, wrapping from 63 back to 0, so a transaction longer than a page overwrites its own earlier bytes and only the newest byte for each slot is kept.

Nothing reaches the array while bytes are being collected. When the front end signals STOP and at least one byte was taken, the block enters a self-timed programming cycle and raises busy. During the first 64 busy cycles it scans the buffer slot by slot and drives the memory write port for each flagged slot only. Busy lasts for the configured program-time count, but never less than the 64-cycle scan. A STOP with no bytes taken starts nothing.

The byte input is a valid/ready stream. A byte moves only in a cycle where byte_valid and byte_ready are both high. byte_ready is high exactly while a transaction is open, and it is low during programming, so a source that holds valid simply waits. Start, STOP and the program-time count are plain control pins.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset, busy, byte_ready and mem_we are all 0.
- R2: A wr_start pulse while busy is low opens a transaction. It takes the row from wr_base bits 14..6 and the column from bits 5..0, and byte_ready is 1 from the next cycle until the transaction closes.
- R3: Each byte taken (byte_valid and byte_ready both high) is stored at the current column, and the column then increments modulo 64 within the same row. A later byte to the same column replaces the earlier one.
- R4: A stop_strobe in an open transaction with at least one byte taken makes busy 1 from the next cycle. Busy stays high for exactly max(prog_cycles, 64) cycles, and it rises for no other reason.
- R5: In busy cycle k (k = 0..63, counted from the first busy cycle), mem_we is 1 exactly when column k was written in the transaction. In that cycle mem_addr is {row, k} and mem_wdata is the newest byte for column k. mem_we is 0 whenever busy is 0 and in busy cycles after the scan.
- R6: A stop_strobe in an open transaction with no byte taken closes it without programming: busy stays 0, mem_we stays 0, and byte_ready falls.
- R7: While busy is 1, byte_ready is 0 and wr_start is ignored, so no transaction is open after busy falls.
- R8: A stop_strobe while no transaction is open has no effect.
- R9: A wr_start during an open transaction discards the bytes taken so far and reopens the transaction at the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| wr_start | input | 1 | Opens a write transaction (one-cycle pulse) |
| wr_base | input | 15 | Base address: row in bits 14..6, column in 5..0 |
| byte_valid | input | 1 | Byte stream valid |
| byte_ready | output | 1 | Byte stream ready, high while a transaction is open |
| byte_data | input | 8 | Byte stream data |
| stop_strobe | input | 1 | Closes the transaction and requests a commit |
| prog_cycles | input | 24 | Programming time in clock cycles |
| busy | output | 1 | Programming cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 15 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The hardest situation to reach is a page-overflow commit. Here the column has wrapped past 63 from a non-zero start and some slots hold a replaced byte, while others were never touched. The bench sweeps transaction lengths from 0 to 70 bytes over shifting start columns, rows and program times (some shorter than the scan). It computes the surviving byte and written flag for each slot arithmetically, so that every wrapped, replaced and skipped slot is compared against the write port. Start pulses and offered bytes are also injected during programming, and one transaction is restarted midway.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  // Transaction phase of the collecting side.
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_OPEN = 1'b1
  } txn_phase_t;
endpackage

// File: rtl/pgbuf_store.sv
// Page buffer: one data byte and one written flag per column.
module pgbuf_store #(
  parameter int DATA_W = 8,
  parameter int COL_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wen,
  input  logic [COL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [COL_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rmark,
  output logic              any_mark
);
  localparam int DEPTH = 1 << COL_W;

  logic [DEPTH-1:0]  mark_vec;
  logic [DATA_W-1:0] data_arr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              m_q;
    logic [DATA_W-1:0] d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_q <= 1'b0;
        d_q <= '0;
      end else if (clr) begin
        m_q <= 1'b0;
      end else if (wen && waddr == COL_W'(i)) begin
        m_q <= 1'b1;
        d_q <= wdata;
      end
    end
    assign mark_vec[i] = m_q;
    assign data_arr[i] = d_q;
  end

  assign rdata    = data_arr[raddr];
  assign rmark    = mark_vec[raddr];
  assign any_mark = |mark_vec;
endmodule

// File: rtl/pgbuf_ctrl.sv
// Transaction control: open/close, row latch and wrapping column counter.
module pgbuf_ctrl import pgbuf_pkg::*; #(
  parameter int ADDR_W = 15,
  parameter int COL_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_start,
  input  logic [ADDR_W-1:0]       wr_base,
  input  logic                    stop_strobe,
  input  logic                    fire,
  input  logic                    any_mark,
  input  logic                    busy,
  output logic                    open,
  output logic [ADDR_W-COL_W-1:0] row,
  output logic [COL_W-1:0]        col,
  output logic                    clr_mask,
  output logic                    launch
);
  localparam int ROW_W = ADDR_W - COL_W;

  txn_phase_t       phase_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             start_ok, stop_ok;

  assign start_ok = wr_start && !busy;
  assign stop_ok  = stop_strobe && (phase_q == PH_OPEN);
  assign launch   = stop_ok && (any_mark || fire);
  assign clr_mask = start_ok && !stop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      row_q   <= '0;
      col_q   <= '0;
    end else if (stop_ok) begin
      phase_q <= PH_IDLE;
    end else if (start_ok) begin
      phase_q <= PH_OPEN;
      row_q   <= wr_base[ADDR_W-1:COL_W];
      col_q   <= wr_base[COL_W-1:0];
    end else if (fire) begin
      col_q   <= col_q + 1'b1;
    end
  end

  assign open = (phase_q == PH_OPEN);
  assign row  = row_q;
  assign col  = col_q;
endmodule

// File: rtl/pgbuf_timer.sv
// Programming cycle: buffer scan plus program-time countdown.
module pgbuf_timer #(
  parameter int CNT_W = 24,
  parameter int COL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [CNT_W-1:0] prog_cycles,
  output logic             busy,
  output logic [COL_W-1:0] scan_idx,
  output logic             scan_act
);
  localparam logic [COL_W-1:0] LAST = {COL_W{1'b1}};

  logic             busy_q, sdone_q;
  logic [CNT_W-1:0] rem_q;
  logic [COL_W-1:0] idx_q;
  logic             scan_end, time_end;

  assign scan_end = sdone_q || (idx_q == LAST);
  assign time_end = (rem_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sdone_q <= 1'b0;
      rem_q   <= '0;
      idx_q   <= '0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      sdone_q <= 1'b0;
      rem_q   <= prog_cycles;
      idx_q   <= '0;
    end else if (busy_q) begin
      if (rem_q != '0) rem_q <= rem_q - 1'b1;
      if (!sdone_q) begin
        if (idx_q == LAST) sdone_q <= 1'b1;
        else               idx_q   <= idx_q + 1'b1;
      end
      if (scan_end && time_end) busy_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign scan_idx = idx_q;
  assign scan_act = busy_q && !sdone_q;
endmodule

// File: rtl/pgbuf_commit.sv
// Page write buffer with a self-timed commit to the memory array.
module pgbuf_commit #(
  parameter int ADDR_W = 15,
  parameter int COL_W  = 6,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_strobe,
  input  logic [CNT_W-1:0]  prog_cycles,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int ROW_W = ADDR_W - COL_W;

  logic             open, fire, any_mark, clr_mask, launch;
  logic             scan_act, rmark;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col, scan_idx;

  assign byte_ready = open;
  assign fire       = byte_valid && open;

  pgbuf_ctrl #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_base(wr_base),
    .stop_strobe(stop_strobe), .fire(fire), .any_mark(any_mark), .busy(busy),
    .open(open), .row(row), .col(col), .clr_mask(clr_mask), .launch(launch)
  );

  pgbuf_store #(.DATA_W(DATA_W), .COL_W(COL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr_mask), .wen(fire), .waddr(col),
    .wdata(byte_data), .raddr(scan_idx), .rdata(mem_wdata), .rmark(rmark),
    .any_mark(any_mark)
  );

  pgbuf_timer #(.CNT_W(CNT_W), .COL_W(COL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .prog_cycles(prog_cycles),
    .busy(busy), .scan_idx(scan_idx), .scan_act(scan_act)
  );

  assign mem_we   = scan_act && rmark;
  assign mem_addr = {row, scan_idx};
endmodule

// File: rtl/pgbuf_commit_chk.sv
// Temporal checks on the page buffer ports.
module pgbuf_commit_chk #(
  parameter int ADDR_W = 15,
  parameter int COL_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              byte_ready,
  input logic              stop_strobe,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  p_rise_from_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_strobe && byte_ready));

  p_write_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_row_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:COL_W]));

  p_close_drops_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_strobe && byte_ready) |=> !byte_ready);

  p_no_ready_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !byte_ready);
endmodule

bind pgbuf_commit pgbuf_commit_chk #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .byte_ready(byte_ready),
  .stop_strobe(stop_strobe), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/pgbuf_commit_test.sv
module pgbuf_commit_test;
  localparam int AW = 15, CW = 6, DW = 8, NW = 24, PAGE = 64;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          wr_start = 1'b0, byte_valid = 1'b0, stop_strobe = 1'b0;
  logic [AW-1:0] wr_base = '0;
  logic [DW-1:0] byte_data = '0;
  logic [NW-1:0] prog_cycles = '0;
  logic          byte_ready, busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int checks = 0, fails = 0;
  logic [7:0] exp_d [PAGE];
  bit         exp_m [PAGE];
  int         exp_row = 0, exp_col = 0;

  always #4 clk = ~clk;  // 8 ns period

  pgbuf_commit uut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_base(wr_base),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .stop_strobe(stop_strobe), .prog_cycles(prog_cycles), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic open_txn(input int base);
    @(negedge clk);
    wr_start = 1'b1;
    wr_base  = AW'(base);
    @(negedge clk);
    wr_start = 1'b0;
    for (int i = 0; i < PAGE; i++) exp_m[i] = 1'b0;
    exp_row = base >> CW;
    exp_col = base % PAGE;
    chk(byte_ready == 1'b1, "R2 ready after open", int'(byte_ready), 1);
  endtask

  task automatic push(input int b);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = DW'(b);
    @(negedge clk);
    byte_valid = 1'b0;
    exp_d[exp_col] = 8'(b);
    exp_m[exp_col] = 1'b1;
    exp_col = (exp_col + 1) % PAGE;
  endtask

  task automatic close_watch(input int p, input bit disturb);
    int pop, n, writes, last_col, wc;
    pop = 0;
    for (int i = 0; i < PAGE; i++) pop += int'(exp_m[i]);
    @(negedge clk);
    prog_cycles = NW'(p);
    stop_strobe = 1'b1;
    @(negedge clk);
    stop_strobe = 1'b0;
    if (pop == 0) begin
      chk(busy == 1'b0, "R6 empty stop keeps busy low", int'(busy), 0);
      chk(byte_ready == 1'b0, "R6 empty stop closes", int'(byte_ready), 0);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(!busy && !mem_we, "R6 no programming", int'(busy) + int'(mem_we), 0);
      end
      return;
    end
    chk(busy == 1'b1, "R4 busy next cycle", int'(busy), 1);
    n = 0; writes = 0; last_col = -1;
    while (busy && n < 100000) begin
      if (n == 0) chk(byte_ready == 1'b0, "R7 ready low in busy", int'(byte_ready), 0);
      if (mem_we) begin
        wc = int'(mem_addr[CW-1:0]);
        writes++;
        chk(n < PAGE && wc == n, "R5 write slot", wc, n);
        chk(int'(mem_addr[AW-1:CW]) == exp_row, "R5 write row", int'(mem_addr[AW-1:CW]), exp_row);
        chk(exp_m[wc], "R5 written flag", 0, 1);
        chk(mem_wdata == exp_d[wc], "R3 newest byte kept", int'(mem_wdata), int'(exp_d[wc]));
        chk(wc > last_col, "R5 single write per slot", wc, last_col + 1);
        last_col = wc;
      end
      if (disturb && n == 5) begin
        wr_start = 1'b1; byte_valid = 1'b1; wr_base = AW'(123);
      end
      if (disturb && n == 7) begin
        wr_start = 1'b0; byte_valid = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    chk(n == ((p > PAGE) ? p : PAGE), "R4 busy length", n, (p > PAGE) ? p : PAGE);
    chk(writes == pop, "R5 write count", writes, pop);
    chk(mem_we == 1'b0, "R5 no write after busy", int'(mem_we), 0);
    if (disturb)
      chk(byte_ready == 1'b0, "R7 start during busy ignored", int'(byte_ready), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(byte_ready == 1'b0, "R1 reset ready", int'(byte_ready), 0);
    chk(mem_we == 1'b0, "R1 reset write", int'(mem_we), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: stop with no open transaction
    stop_strobe = 1'b1;
    @(negedge clk);
    stop_strobe = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && byte_ready == 1'b0, "R8 idle stop ignored", int'(busy), 0);

    // R3 R4 R5 R6: length sweep 0..70 with shifting start column, row and time
    for (int n = 0; n <= 70; n++) begin
      int base, p;
      base = (((n * 37) % 512) << CW) | ((n * 11) % PAGE);
      p = (n % 3 == 0) ? 20 : ((n % 3 == 1) ? PAGE : PAGE + n);
      open_txn(base);
      for (int i = 0; i < n; i++) push((n * 5 + i * 29 + 1) & 255);
      close_watch(p, (n % 10) == 3);
    end

    // R9: restart in the middle of a transaction
    open_txn((17 << CW) | 60);
    for (int i = 0; i < 3; i++) push(200 + i);
    open_txn((300 << CW) | 2);
    push(7);
    push(9);
    close_watch(70, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule